// File: doc/BRIEF.md
# Half-Step Programmable Clock Divider

This block divides its reference clock by a ratio that moves in steps of one half. A 32-bit control word holds a division enable flag and two 6-bit divide fields. A mode input picks which field is in force. With the enable flag set, the output runs at twice the reference frequency divided by (field + 2). The ratio therefore spans 1.0 to 32.5 in half steps. With the flag clear, the output is the reference clock itself.

The divider counts in half periods of the reference. Each reference cycle it registers the level for the high phase and the level for the low phase. The output multiplexes those two levels with the reference clock, so odd divisors use both clock edges. The high part of each output period is the longer one when the divisor is odd. A new setting is adopted only when the running output period completes, so a reprogram never produces a shortened pulse. A status port reports the divisor that is currently in use, counted in half periods of the reference.

Top module: `halfstep_clk_div`

## Requirements
- R1: A synchronous active-high reset clears the control word to 0. The block is then in bypass and `eff_div` reads 2.
- R2: A write changes only bit 31 and the fields at bits [5:0] and [13:8] (mask 0x80003F3F). All other bits of `ctrl_rd` read 0.
- R3: With bit 31 clear, `div_clk` follows the reference: high for one half period and low for one half period. The divide fields have no effect.
- R4: With bit 31 set, one output period lasts D = field + 2 half periods of the reference, giving an output frequency of 2·ref/D.
- R5: With `alt_mode` high, the field at bits [13:8] gives D. With `alt_mode` low, the field at bits [5:0] gives D.
- R6: Each output period is high for ceil(D/2) half periods and then low for floor(D/2) half periods.
- R7: A new setting takes effect only at the end of a complete output period. Across a change, every high run has the old or the new high length, and no low run is shorter than the smaller of the old and new low lengths.
- R8: `eff_div` reports the D in use (field + 2) while dividing, and 2 while in bypass. It changes only when a setting is adopted.
- R9: The extreme fields work. Field 0 gives D = 2 (1 high, 1 low), and field 63 gives D = 65 (33 high, 32 low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data; only masked bits are stored |
| alt_mode | input | 1 | High selects the field at bits [13:8] |
| ctrl_rd | output | 32 | Current control word |
| div_clk | output | 1 | Divided (or bypassed) clock |
| eff_div | output | 7 | Divisor in use, in half periods of the reference |

## Verification
The bench builds the block with its default parameters: 6-bit fields at bit 0 and bit 8, and the enable flag at bit 31. These defaults cover the full divisor span from 2 to 65, including both extreme fields and a mix of odd and even divisors. The bench samples the output in the middle of every reference half period and measures the lengths of the high and low runs. Reprogramming in the middle of a long period exposes any setting that is adopted before its period boundary.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

  localparam int unsigned CTRL_W  = 32;
  localparam int unsigned FIELD_W = 6;
  localparam int unsigned LO_LSB  = 0;
  localparam int unsigned ALT_LSB = 8;
  localparam int unsigned EN_BIT  = 31;
  localparam int unsigned DIV_W   = FIELD_W + 1;

  // divisor in half reference periods for a given field value
  function automatic int unsigned halves_of(input int unsigned field);
    return field + 2;
  endfunction

  // half periods spent high in one output period
  function automatic int unsigned high_halves(input int unsigned d);
    return (d + 1) / 2;
  endfunction

  // half periods spent low in one output period
  function automatic int unsigned low_halves(input int unsigned d);
    return d / 2;
  endfunction

endpackage

// File: rtl/hsd_ctrl_reg.sv
module hsd_ctrl_reg
  import hsd_pkg::*;
#(
  parameter int unsigned P_CTRL_W  = CTRL_W,
  parameter int unsigned P_FIELD_W = FIELD_W,
  parameter int unsigned P_LO_LSB  = LO_LSB,
  parameter int unsigned P_ALT_LSB = ALT_LSB,
  parameter int unsigned P_EN_BIT  = EN_BIT,
  parameter int unsigned P_DIV_W   = P_FIELD_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [P_CTRL_W-1:0] wr_data,
  input  logic                alt_mode,
  output logic [P_CTRL_W-1:0] ctrl_q,
  output logic [P_DIV_W-1:0]  req_div,
  output logic                req_byp
);

  localparam logic [P_CTRL_W-1:0] FMASK = P_CTRL_W'((1 << P_FIELD_W) - 1);
  localparam logic [P_CTRL_W-1:0] WMASK = (P_CTRL_W'(1) << P_EN_BIT)
                                        | (FMASK << P_LO_LSB)
                                        | (FMASK << P_ALT_LSB);

  logic [P_FIELD_W-1:0] lo_field;
  logic [P_FIELD_W-1:0] alt_field;
  logic [P_FIELD_W-1:0] sel_field;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= (ctrl_q & ~WMASK) | (wr_data & WMASK);
    end
  end

  assign lo_field  = ctrl_q[P_LO_LSB  +: P_FIELD_W];
  assign alt_field = ctrl_q[P_ALT_LSB +: P_FIELD_W];
  assign sel_field = alt_mode ? alt_field : lo_field;

  always_comb begin
    req_div = P_DIV_W'(halves_of(int'(sel_field)));
    req_byp = !ctrl_q[P_EN_BIT];
  end

endmodule

// File: rtl/hsd_phase_gen.sv
module hsd_phase_gen
  import hsd_pkg::*;
#(
  parameter int unsigned P_DIV_W = DIV_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [P_DIV_W-1:0] req_div,
  input  logic               req_byp,
  output logic               hi_q,
  output logic               lo_q,
  output logic [P_DIV_W-1:0] act_div,
  output logic               act_byp,
  output logic [P_DIV_W-1:0] pos_q,
  output logic               load_evt
);

  localparam int unsigned CW = P_DIV_W + 1;
  localparam logic [P_DIV_W-1:0] BYP_DIV = P_DIV_W'(2);

  logic [CW-1:0]      half_a;
  logic [CW-1:0]      p1;
  logic [CW-1:0]      p2;
  logic [CW-1:0]      d_ext;
  logic               bit0;
  logic               bit1;
  logic               mid_load;
  logic               end_load;
  logic [P_DIV_W-1:0] pos_n;

  always_comb begin
    d_ext    = CW'(act_div);
    half_a   = CW'(high_halves(int'(act_div)));
    p1       = CW'(pos_q) + CW'(1);
    p2       = CW'(pos_q) + CW'(2);
    bit0     = 1'b1;
    bit1     = 1'b0;
    mid_load = 1'b0;
    end_load = 1'b0;
    pos_n    = '0;
    if (act_byp) begin
      // reference pass-through: high half then low half, period ends each cycle
      end_load = 1'b1;
    end else begin
      bit0 = (CW'(pos_q) < half_a);
      if (p1 == d_ext) begin
        // period ends after the first half; second half opens the next setting
        mid_load = 1'b1;
        if (req_byp) begin
          bit1  = 1'b0;
          pos_n = '0;
        end else begin
          bit1  = 1'b1;
          pos_n = P_DIV_W'(1);
        end
      end else begin
        bit1 = (p1 < half_a);
        if (p2 == d_ext) begin
          end_load = 1'b1;
          pos_n    = '0;
        end else begin
          pos_n = P_DIV_W'(p2);
        end
      end
    end
  end

  assign load_evt = mid_load | end_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
      pos_q   <= '0;
      act_div <= BYP_DIV;
      act_byp <= 1'b1;
    end else begin
      hi_q  <= bit0;
      lo_q  <= bit1;
      pos_q <= pos_n;
      if (load_evt) begin
        act_div <= req_byp ? BYP_DIV : req_div;
        act_byp <= req_byp;
      end
    end
  end

endmodule

// File: rtl/halfstep_clk_div.sv
module halfstep_clk_div
  import hsd_pkg::*;
#(
  parameter int unsigned P_CTRL_W  = CTRL_W,
  parameter int unsigned P_FIELD_W = FIELD_W,
  parameter int unsigned P_LO_LSB  = LO_LSB,
  parameter int unsigned P_ALT_LSB = ALT_LSB,
  parameter int unsigned P_EN_BIT  = EN_BIT,
  parameter int unsigned P_DIV_W   = P_FIELD_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [P_CTRL_W-1:0] wr_data,
  input  logic                alt_mode,
  output logic [P_CTRL_W-1:0] ctrl_rd,
  output logic                div_clk,
  output logic [P_DIV_W-1:0]  eff_div
);

  logic [P_DIV_W-1:0] req_div;
  logic               req_byp;
  logic               gen_hi;
  logic               gen_lo;
  logic [P_DIV_W-1:0] gen_div;
  logic               gen_byp;
  logic [P_DIV_W-1:0] gen_pos;
  logic               gen_load;

  hsd_ctrl_reg #(
    .P_CTRL_W (P_CTRL_W),
    .P_FIELD_W(P_FIELD_W),
    .P_LO_LSB (P_LO_LSB),
    .P_ALT_LSB(P_ALT_LSB),
    .P_EN_BIT (P_EN_BIT),
    .P_DIV_W  (P_DIV_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .alt_mode(alt_mode),
    .ctrl_q  (ctrl_rd),
    .req_div (req_div),
    .req_byp (req_byp)
  );

  hsd_phase_gen #(
    .P_DIV_W(P_DIV_W)
  ) u_gen (
    .clk     (clk),
    .rst     (rst),
    .req_div (req_div),
    .req_byp (req_byp),
    .hi_q    (gen_hi),
    .lo_q    (gen_lo),
    .act_div (gen_div),
    .act_byp (gen_byp),
    .pos_q   (gen_pos),
    .load_evt(gen_load)
  );

  // high phase of the reference shows the first half level, low phase the second
  assign div_clk = clk ? gen_hi : gen_lo;
  assign eff_div = gen_div;

endmodule

// File: rtl/hsd_checker.sv
module hsd_checker #(
  parameter int unsigned P_CTRL_W = 32,
  parameter int unsigned P_DIV_W  = 7
) (
  input logic                clk,
  input logic                rst,
  input logic [P_CTRL_W-1:0] ctrl_rd,
  input logic [P_DIV_W-1:0]  eff_div,
  input logic                gen_hi,
  input logic                gen_lo,
  input logic                gen_byp,
  input logic [P_DIV_W-1:0]  gen_pos,
  input logic                gen_load
);

  localparam logic [P_CTRL_W-1:0] KEEP = 32'h8000_3F3F;
  localparam int unsigned MAXD = 65;

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: the cycle after reset leaves a cleared word and bypass
  always @(posedge clk) begin
    if (rst_d === 1'b1 && rst === 1'b0) begin
      a_r1_reset_state: assert (ctrl_rd == '0 && eff_div == P_DIV_W'(2));
    end
  end

  a_r2_mask_bits: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rd & ~KEEP) == '0);

  a_r8_div_range: assert property (@(posedge clk) disable iff (rst)
    (eff_div >= P_DIV_W'(2)) && (eff_div <= P_DIV_W'(MAXD)));

  a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
    !gen_load |=> $stable(eff_div));

  a_r4_pos_inside: assert property (@(posedge clk) disable iff (rst)
    gen_pos < eff_div);

  a_r3_bypass_wave: assert property (@(posedge clk) disable iff (rst)
    gen_byp |=> (gen_hi && !gen_lo));

  a_r8_bypass_reads2: assert property (@(posedge clk) disable iff (rst)
    gen_byp |-> eff_div == P_DIV_W'(2));

endmodule

bind halfstep_clk_div hsd_checker #(
  .P_CTRL_W(P_CTRL_W),
  .P_DIV_W (P_DIV_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ctrl_rd (ctrl_rd),
  .eff_div (eff_div),
  .gen_hi  (gen_hi),
  .gen_lo  (gen_lo),
  .gen_byp (gen_byp),
  .gen_pos (gen_pos),
  .gen_load(gen_load)
);

// File: tb/tb_halfstep_clk_div.sv
`timescale 1ns/1ps
module tb_halfstep_clk_div;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        alt_mode = 1'b0;
  logic [31:0] ctrl_rd;
  logic        div_clk;
  logic [6:0]  eff_div;

  halfstep_clk_div dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .alt_mode(alt_mode), .ctrl_rd(ctrl_rd), .div_clk(div_clk), .eff_div(eff_div)
  );

  always #10 clk = ~clk;

  int n_vec  = 0;
  int n_miss = 0;
  bit done   = 0;

  typedef struct { int h; int l; string req; } exp_t;
  exp_t q[$];

  logic hv;
  event hs_ev;

  // one sample in the middle of every reference half period
  always @(posedge clk) begin #5; hv = div_clk; ->hs_ev; end
  always @(negedge clk) begin #5; hv = div_clk; ->hs_ev; end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_miss++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
  endtask

  // monitor: measure one full period per queued item
  initial begin
    forever begin
      int hc;
      int lc;
      exp_t e;
      while (q.size() == 0) @(posedge clk);
      do @(hs_ev); while (hv !== 1'b0);
      do @(hs_ev); while (hv !== 1'b1);
      hc = 1; lc = 0;
      forever begin
        @(hs_ev);
        if (hv === 1'b1) begin
          if (lc == 0) hc++;
          else break;
        end else lc++;
      end
      e = q.pop_front();
      chk(hc == e.h, e.req, "high halves", hc, e.h);
      chk(lc == e.l, e.req, "low halves", lc, e.l);
    end
  end

  task automatic write_ctrl(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: push the expected shape for n periods and wait for the monitor
  task automatic expect_shape(input int d, input string req, input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.h = (d + 1) / 2; e.l = d / 2; e.req = req;
      q.push_back(e);
    end
    while (q.size() != 0) @(posedge clk);
  endtask

  task automatic settle();
    repeat (200) @(posedge clk);
    @(negedge clk); #5;
  endtask

  // R7: reprogram mid-period and inspect every complete run around the switch
  task automatic switch_check(input int d_old, input int d_new);
    logic s [0:159];
    int run;
    int bad;
    int first_end;
    int lmin;
    int ho;
    int hn;
    ho = (d_old + 1) / 2; hn = (d_new + 1) / 2;
    lmin = (d_old / 2 < d_new / 2) ? d_old / 2 : d_new / 2;
    bad = -1;
    @(negedge clk); wr_en = 1'b1; wr_data = 32'h8000_0000 | 32'(d_new - 2);
    @(negedge clk); wr_en = 1'b0;
    for (int i = 0; i < 160; i++) begin @(hs_ev); s[i] = hv; end
    first_end = 1;
    while (first_end < 160 && s[first_end] == s[0]) first_end++;
    run = 1;
    for (int i = first_end + 1; i < 160; i++) begin
      if (s[i] == s[i-1]) run++;
      else begin
        if (s[i-1] == 1'b1 && run != ho && run != hn && bad < 0) bad = run;
        if (s[i-1] == 1'b0 && run < lmin && bad < 0) bad = run;
        run = 1;
      end
    end
    chk(bad < 0, "R7", "run length across switch", bad, -1);
  endtask

  initial begin
    #(150000 * 20);
    n_vec++; n_miss++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #5;
    chk(ctrl_rd == 32'h0, "R1", "ctrl after reset", int'(ctrl_rd), 0);
    chk(eff_div == 7'd2, "R1", "eff_div after reset", int'(eff_div), 2);

    // R3 bypass with nonzero fields, R2 readback
    write_ctrl(32'h0000_1505);
    settle();
    chk(ctrl_rd == 32'h0000_1505, "R2", "ctrl stored", int'(ctrl_rd), 32'h1505);
    chk(eff_div == 7'd2, "R8", "eff_div bypass", int'(eff_div), 2);
    expect_shape(2, "R3", 3);
    alt_mode = 1'b1; settle();
    expect_shape(2, "R3", 2);
    alt_mode = 1'b0;

    // R4 R6 odd divisor from low field
    write_ctrl(32'h8000_0005);
    settle();
    chk(eff_div == 7'd7, "R8", "eff_div field 5", int'(eff_div), 7);
    expect_shape(7, "R4", 3);

    // R5 alternate field
    write_ctrl(32'h8000_0A05);
    alt_mode = 1'b1;
    settle();
    chk(eff_div == 7'd12, "R5", "eff_div alt field", int'(eff_div), 12);
    expect_shape(12, "R5", 2);
    alt_mode = 1'b0; settle();
    chk(eff_div == 7'd7, "R5", "eff_div low field", int'(eff_div), 7);
    expect_shape(7, "R6", 2);

    // R2 mask, R9 top extreme
    write_ctrl(32'hFFFF_FFFF);
    alt_mode = 1'b1;
    settle();
    chk(ctrl_rd == 32'h8000_3F3F, "R2", "masked write", int'(ctrl_rd), 32'h80003F3F);
    chk(eff_div == 7'd65, "R9", "eff_div max", int'(eff_div), 65);
    expect_shape(65, "R9", 2);

    // R9 bottom extreme
    alt_mode = 1'b0;
    write_ctrl(32'h8000_0000);
    settle();
    chk(eff_div == 7'd2, "R9", "eff_div min", int'(eff_div), 2);
    expect_shape(2, "R9", 3);

    // even divisor, then R7 switch mid-period
    write_ctrl(32'h8000_0012);
    settle();
    expect_shape(20, "R4", 2);
    repeat (3) @(posedge clk);
    switch_check(20, 3);
    settle();
    expect_shape(3, "R6", 3);
    switch_check(3, 20);

    // back to bypass
    write_ctrl(32'h0000_0000);
    settle();
    chk(eff_div == 7'd2, "R8", "eff_div back to bypass", int'(eff_div), 2);
    expect_shape(2, "R3", 3);

    summary();
    $finish;
  end

endmodule